// File: doc/BRIEF.md
# Single-Precision Round-and-Pack Unit

This block is the last stage of a single-precision arithmetic pipeline. An upstream datapath delivers an unpacked result: a sign, a signed unbiased exponent, and a normalized significand. The significand has a leading one, the fraction bits and two extra low-order bits, plus a separate sticky bit that holds the OR of everything discarded further down. The unit applies one of four rounding directions, which a 2-bit mode input selects. It renormalizes when rounding carries out, and it drops gradually into the denormal range when the exponent is too small. On overflow it saturates to infinity or to the largest finite value, as the mode requires. It then packs the result into a 32-bit IEEE 754 word.

Flag inputs mark the operand as NaN, infinity or zero, so that special results bypass rounding. The packed word appears one clock after it is accepted, together with inexact, overflow and underflow flags. A two-state controller tracks whether the output register holds a fresh result. `ST_IDLE` means no result is pending and `ST_EMIT` means a result is presented. The transitions are: *accept* (`ST_IDLE`→`ST_EMIT` when `in_valid` is high), *stream* (`ST_EMIT`→`ST_EMIT` when `in_valid` stays high), *drain* (`ST_EMIT`→`ST_IDLE` when `in_valid` is low), and *rest* (`ST_IDLE`→`ST_IDLE` otherwise).

Top module: `sp_round_pack`

## Requirements
- R1: Mode 00 selects round-to-nearest. A discarded part of exactly one half (guard bit `in_sig[1]`=1, `in_sig[0]`=0, sticky 0) rounds to the neighbour whose lowest fraction bit is 0.
- R2: In mode 00, a discarded part above one half (guard 1 and either round bit or sticky set) rounds the magnitude up.
- R3: Mode 01 rounds toward zero. Discarded bits are dropped, and a finite operand never produces an infinity.
- R4: Mode 10 rounds toward +infinity: positive results go up in magnitude when any discarded bit is nonzero, and negative results are truncated. Mode 11 rounds toward −infinity and does the mirror image.
- R5: When rounding carries out of the 24-bit significand, the fraction becomes zero and the exponent field is incremented by one.
- R6: A biased exponent of 255 or more after rounding sets the overflow and inexact flags. The word becomes signed infinity in mode 00, in mode 10 for positive results and in mode 11 for negative results. Otherwise it becomes the signed largest finite value, exponent field 254 with all fraction bits one.
- R7: A biased exponent of 0 or less shifts the significand right by (1 − biased exponent) bits into a denormal, with exponent field 0 and no implicit one. An input of exactly 2^-149 packs to 0x00000001 with no flags.
- R8: The underflow flag is set when the value was below the normal range before rounding and the result is inexact. A denormal that rounds up to 2^-126 gives exponent field 1.
- R9: The inexact flag is set exactly when a discarded bit (guard, round or sticky, including bits shifted out for denormals) is nonzero.
- R10: A NaN input gives the quiet NaN 0x7FC00000 with all flags clear. This takes priority over the infinity and zero inputs.
- R11: An infinity input gives exponent field 255, fraction 0, with the input sign. A zero input gives the signed zero. Neither raises a flag.
- R12: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R13: While `rst_n` is low, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_sign | input | 1 | Sign of the operand |
| in_exp | input | 10 | Signed unbiased exponent (value = 1.f × 2^in_exp) |
| in_sig | input | 26 | Leading one, 23 fraction bits, guard bit, round bit |
| in_sticky | input | 1 | OR of all lower discarded bits |
| in_nan | input | 1 | Operand is NaN |
| in_inf | input | 1 | Operand is infinity |
| in_zero | input | 1 | Operand is zero |
| rnd_mode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward −inf |
| out_valid | output | 1 | Packed result present |
| out_word | output | 32 | Packed IEEE 754 single-precision word |
| flag_inexact | output | 1 | Result differs from the exact value |
| flag_overflow | output | 1 | Result exceeded the finite range |
| flag_underflow | output | 1 | Tiny and inexact result |

## Verification
The bench builds the unit with its default parameters: 23 fraction bits, two extra bits, an 8-bit exponent field and a 10-bit input exponent. The input exponent spans −512 to 511. That range reaches overflow both directly and through a rounding carry, every denormal shift from 1 bit to the full 26-bit flush, and shifts clamped far below the smallest denormal. With two extra bits, ties and above-half cases can be separated by the guard, round and sticky bits. The scoreboard pairs each accepted operand with its hand-derived word and flags, including back-to-back operands and idle gaps.

// File: rtl/rp_pkg.sv
package rp_pkg;
    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_ZERO      = 2'b01,
        RM_UP        = 2'b10,
        RM_DOWN      = 2'b11
    } rmode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } rp_state_e;
endpackage

// File: rtl/rp_prescale.sv
// Biases the exponent and, for values below the normal range, shifts the
// significand right into denormal position, folding shifted-out bits into sticky.
module rp_prescale #(
    parameter int FRAC_W = 23,
    parameter int EXT_W  = 2,
    parameter int EXP_W  = 10,
    parameter int EXPF_W = 8,
    localparam int SIG_W = 1 + FRAC_W + EXT_W,
    localparam int BE_W  = EXP_W + 2
) (
    input  logic signed [EXP_W-1:0] in_exp,
    input  logic [SIG_W-1:0]        in_sig,
    input  logic                    in_sticky,
    output logic [SIG_W-1:0]        work_sig,
    output logic                    work_sticky,
    output logic                    tiny,
    output logic signed [BE_W-1:0]  biased_exp
);
    localparam int BIAS = (1 << (EXPF_W - 1)) - 1;
    localparam int SH_W = $clog2(SIG_W + 1);

    logic signed [BE_W-1:0] shift_full;
    logic [SH_W-1:0]        shift_amt;
    logic [2*SIG_W-1:0]     wide;

    always_comb begin
        biased_exp = $signed({{2{in_exp[EXP_W-1]}}, in_exp}) + $signed(BE_W'(BIAS));
        tiny       = biased_exp < $signed(BE_W'(1));
        shift_full = $signed(BE_W'(1)) - biased_exp;
        if (!tiny)
            shift_amt = '0;
        else if (shift_full >= $signed(BE_W'(SIG_W)))
            shift_amt = SH_W'(SIG_W);
        else
            shift_amt = shift_full[SH_W-1:0];
        wide        = {in_sig, {SIG_W{1'b0}}} >> shift_amt;
        work_sig    = wide[2*SIG_W-1:SIG_W];
        work_sticky = in_sticky | (|wide[SIG_W-1:0]);
    end
endmodule

// File: rtl/rp_rounder.sv
// Decides the rounding increment for the selected direction and adds it.
module rp_rounder
    import rp_pkg::*;
#(
    parameter int FRAC_W = 23,
    parameter int EXT_W  = 2,
    localparam int SIG_W = 1 + FRAC_W + EXT_W
) (
    input  logic [SIG_W-1:0]  work_sig,
    input  logic              work_sticky,
    input  logic              sign,
    input  rmode_e            mode,
    output logic [FRAC_W+1:0] mant,
    output logic              inexact
);
    logic [FRAC_W:0] keep;
    logic            guard_b;
    logic            round_b;
    logic            any_lost;
    logic            inc;

    assign keep    = work_sig[SIG_W-1:EXT_W];
    assign guard_b = work_sig[EXT_W-1];

    generate
        if (EXT_W > 1) begin : g_multi_ext
            assign round_b = |work_sig[EXT_W-2:0];
        end else begin : g_single_ext
            assign round_b = 1'b0;
        end
    endgenerate

    always_comb begin
        any_lost = guard_b | round_b | work_sticky;
        unique case (mode)
            RM_NEAR_EVEN: inc = guard_b & (round_b | work_sticky | keep[0]);
            RM_ZERO:      inc = 1'b0;
            RM_UP:        inc = ~sign & any_lost;
            RM_DOWN:      inc = sign & any_lost;
        endcase
        mant    = {1'b0, keep} + {{(FRAC_W+1){1'b0}}, inc};
        inexact = any_lost;
    end
endmodule

// File: rtl/rp_packer.sv
// Renormalizes after carry, resolves overflow and special operands, builds the word.
module rp_packer
    import rp_pkg::*;
#(
    parameter int FRAC_W = 23,
    parameter int EXP_W  = 10,
    parameter int EXPF_W = 8,
    localparam int BE_W  = EXP_W + 2,
    localparam int WORD_W = 1 + EXPF_W + FRAC_W
) (
    input  logic                   sign,
    input  logic [FRAC_W+1:0]      mant,
    input  logic signed [BE_W-1:0] biased_exp,
    input  logic                   tiny,
    input  logic                   rnd_inexact,
    input  logic                   is_nan,
    input  logic                   is_inf,
    input  logic                   is_zero,
    input  rmode_e                 mode,
    output logic [WORD_W-1:0]      word,
    output logic                   f_nx,
    output logic                   f_of,
    output logic                   f_uf
);
    localparam int EMAX_F = (1 << EXPF_W) - 1;

    logic signed [BE_W-1:0] exp_fin;
    logic [FRAC_W-1:0]      frac;
    logic                   ovf;
    logic                   to_inf;

    always_comb begin
        if (tiny)
            exp_fin = $signed({{(BE_W-1){1'b0}}, mant[FRAC_W]});
        else
            exp_fin = biased_exp + $signed({{(BE_W-1){1'b0}}, mant[FRAC_W+1]});
        frac   = mant[FRAC_W+1] ? mant[FRAC_W:1] : mant[FRAC_W-1:0];
        ovf    = !tiny && (exp_fin >= $signed(BE_W'(EMAX_F)));
        to_inf = (mode == RM_NEAR_EVEN) || (mode == RM_UP && !sign) ||
                 (mode == RM_DOWN && sign);

        f_nx = 1'b0;
        f_of = 1'b0;
        f_uf = 1'b0;
        if (is_nan) begin
            word = {1'b0, {EXPF_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
        end else if (is_inf) begin
            word = {sign, {EXPF_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (is_zero) begin
            word = {sign, {(WORD_W-1){1'b0}}};
        end else if (ovf) begin
            f_nx = 1'b1;
            f_of = 1'b1;
            if (to_inf)
                word = {sign, {EXPF_W{1'b1}}, {FRAC_W{1'b0}}};
            else
                word = {sign, EXPF_W'(EMAX_F - 1), {FRAC_W{1'b1}}};
        end else begin
            word = {sign, exp_fin[EXPF_W-1:0], frac};
            f_nx = rnd_inexact;
            f_uf = tiny & rnd_inexact;
        end
    end
endmodule

// File: rtl/sp_round_pack.sv
module sp_round_pack
    import rp_pkg::*;
#(
    parameter int FRAC_W = 23,
    parameter int EXT_W  = 2,
    parameter int EXP_W  = 10,
    parameter int EXPF_W = 8,
    localparam int SIG_W  = 1 + FRAC_W + EXT_W,
    localparam int BE_W   = EXP_W + 2,
    localparam int WORD_W = 1 + EXPF_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sign,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic [SIG_W-1:0]  in_sig,
    input  logic              in_sticky,
    input  logic              in_nan,
    input  logic              in_inf,
    input  logic              in_zero,
    input  logic [1:0]        rnd_mode,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              flag_inexact,
    output logic              flag_overflow,
    output logic              flag_underflow
);
    rp_state_e state_q, state_d;

    logic [SIG_W-1:0]       work_sig;
    logic                   work_sticky;
    logic                   tiny;
    logic signed [BE_W-1:0] biased_exp;
    logic [FRAC_W+1:0]      mant;
    logic                   rnd_inexact;
    logic [WORD_W-1:0]      word_c;
    logic                   nx_c, of_c, uf_c;
    rmode_e                 mode;

    assign mode = rmode_e'(rnd_mode);

    rp_prescale #(.FRAC_W(FRAC_W), .EXT_W(EXT_W), .EXP_W(EXP_W), .EXPF_W(EXPF_W)) u_pre (
        .in_exp     ($signed(in_exp)),
        .in_sig     (in_sig),
        .in_sticky  (in_sticky),
        .work_sig   (work_sig),
        .work_sticky(work_sticky),
        .tiny       (tiny),
        .biased_exp (biased_exp)
    );

    rp_rounder #(.FRAC_W(FRAC_W), .EXT_W(EXT_W)) u_rnd (
        .work_sig   (work_sig),
        .work_sticky(work_sticky),
        .sign       (in_sign),
        .mode       (mode),
        .mant       (mant),
        .inexact    (rnd_inexact)
    );

    rp_packer #(.FRAC_W(FRAC_W), .EXP_W(EXP_W), .EXPF_W(EXPF_W)) u_pack (
        .sign       (in_sign),
        .mant       (mant),
        .biased_exp (biased_exp),
        .tiny       (tiny),
        .rnd_inexact(rnd_inexact),
        .is_nan     (in_nan),
        .is_inf     (in_inf),
        .is_zero    (in_zero),
        .mode       (mode),
        .word       (word_c),
        .f_nx       (nx_c),
        .f_of       (of_c),
        .f_uf       (uf_c)
    );

    // next-state: accept / stream / drain / rest
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_word       <= '0;
            flag_inexact   <= 1'b0;
            flag_overflow  <= 1'b0;
            flag_underflow <= 1'b0;
        end else if (in_valid) begin
            out_word       <= word_c;
            flag_inexact   <= nx_c;
            flag_overflow  <= of_c;
            flag_underflow <= uf_c;
        end
    end

    always_comb out_valid = (state_q == ST_EMIT);
endmodule

// File: rtl/rp_checker.sv
module rp_checker #(
    parameter int FRAC_W = 23,
    parameter int EXPF_W = 8,
    localparam int WORD_W = 1 + EXPF_W + FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_nan,
    input logic              in_inf,
    input logic [1:0]        rnd_mode,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_word,
    input logic              flag_inexact,
    input logic              flag_overflow,
    input logic              flag_underflow
);
    logic [EXPF_W-1:0] fld_e;
    logic [FRAC_W-1:0] fld_f;
    assign fld_e = out_word[FRAC_W+EXPF_W-1:FRAC_W];
    assign fld_f = out_word[FRAC_W-1:0];

    p_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_reset_quiet_r13: assert property (@(posedge clk)
        !rst_n |-> !out_valid);
    p_ovf_inexact_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && flag_overflow |-> flag_inexact);
    p_uf_inexact_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && flag_underflow |-> flag_inexact && fld_e <= EXPF_W'(1));
    p_nan_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_nan |=> fld_e == {EXPF_W{1'b1}} && fld_f != '0 &&
                               !flag_inexact && !flag_overflow && !flag_underflow);
    p_inf_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_inf && !in_nan |=> fld_e == {EXPF_W{1'b1}} && fld_f == '0);
    p_rtz_finite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && rnd_mode == 2'b01 && !in_nan && !in_inf |=> fld_e != {EXPF_W{1'b1}});
endmodule

bind sp_round_pack rp_checker #(.FRAC_W(FRAC_W), .EXPF_W(EXPF_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_nan        (in_nan),
    .in_inf        (in_inf),
    .rnd_mode      (rnd_mode),
    .out_valid     (out_valid),
    .out_word      (out_word),
    .flag_inexact  (flag_inexact),
    .flag_overflow (flag_overflow),
    .flag_underflow(flag_underflow)
);

// File: tb/sim_sp_round_pack.sv
`timescale 1ns/1ps
module sim_sp_round_pack;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sign = 1'b0;
    logic [9:0]  in_exp = '0;
    logic [25:0] in_sig = '0;
    logic        in_sticky = 1'b0;
    logic        in_nan = 1'b0;
    logic        in_inf = 1'b0;
    logic        in_zero = 1'b0;
    logic [1:0]  rnd_mode = 2'b00;
    logic        out_valid;
    logic [31:0] out_word;
    logic        flag_inexact, flag_overflow, flag_underflow;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] word;
        logic [2:0]  flags;   // {inexact, overflow, underflow}
        string       tag;
    } exp_item_t;
    exp_item_t sb[$];

    always #2 clk = ~clk;   // 250 MHz

    sp_round_pack u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
        .in_exp(in_exp), .in_sig(in_sig), .in_sticky(in_sticky),
        .in_nan(in_nan), .in_inf(in_inf), .in_zero(in_zero), .rnd_mode(rnd_mode),
        .out_valid(out_valid), .out_word(out_word), .flag_inexact(flag_inexact),
        .flag_overflow(flag_overflow), .flag_underflow(flag_underflow)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // driver: called at a falling edge, leaves after the next one
    task automatic send(input logic s, input int e, input logic [25:0] sig,
                        input logic st, input logic [1:0] m, input logic [2:0] spc,
                        input logic [31:0] xw, input logic [2:0] xf, input string tag);
        exp_item_t it;
        in_valid  = 1'b1;
        in_sign   = s;
        in_exp    = 10'(e);
        in_sig    = sig;
        in_sticky = st;
        rnd_mode  = m;
        {in_nan, in_inf, in_zero} = spc;
        it.word = xw; it.flags = xf; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R12", "unexpected out_valid", 32'(out_valid), 32'd0);
            end else begin
                exp_item_t it;
                it = sb.pop_front();
                check(out_word == it.word, it.tag, "word", out_word, it.word);
                check({flag_inexact, flag_overflow, flag_underflow} == it.flags, it.tag,
                      "flags{nx,of,uf}", 32'({flag_inexact, flag_overflow, flag_underflow}),
                      32'(it.flags));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R13", "out_valid in reset", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R12", "idle after reset", 32'(out_valid), 32'd0);

        // R1 ties to even
        send(0, 0,    26'h2000000, 0, 2'b00, 3'b000, 32'h3F800000, 3'b000, "R1");
        send(0, 0,    26'h2000002, 0, 2'b00, 3'b000, 32'h3F800000, 3'b100, "R1");
        send(0, 0,    26'h2000006, 0, 2'b00, 3'b000, 32'h3F800002, 3'b100, "R1");
        // R2 above half via sticky
        send(0, 0,    26'h2000002, 1, 2'b00, 3'b000, 32'h3F800001, 3'b100, "R2");
        // R3 toward zero
        send(0, 0,    26'h2000002, 1, 2'b01, 3'b000, 32'h3F800000, 3'b100, "R3");
        send(0, 0,    26'h3FFFFFF, 0, 2'b01, 3'b000, 32'h3FFFFFFF, 3'b100, "R3");
        // R4 directed modes
        send(0, 0,    26'h2000001, 0, 2'b10, 3'b000, 32'h3F800001, 3'b100, "R4");
        send(1, 0,    26'h2000001, 0, 2'b10, 3'b000, 32'hBF800000, 3'b100, "R4");
        send(1, 0,    26'h2000001, 0, 2'b11, 3'b000, 32'hBF800001, 3'b100, "R4");
        send(0, 0,    26'h2000001, 0, 2'b11, 3'b000, 32'h3F800000, 3'b100, "R4");
        in_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        check(out_valid == 1'b0, "R12", "out_valid after gap", 32'(out_valid), 32'd0);
        // R5 carry renormalization
        send(0, 0,    26'h3FFFFFE, 0, 2'b00, 3'b000, 32'h40000000, 3'b100, "R5");
        // R6 overflow
        send(0, 127,  26'h3FFFFFE, 0, 2'b00, 3'b000, 32'h7F800000, 3'b110, "R6");
        send(0, 200,  26'h2000000, 0, 2'b01, 3'b000, 32'h7F7FFFFF, 3'b110, "R6");
        send(1, 200,  26'h2000000, 0, 2'b10, 3'b000, 32'hFF7FFFFF, 3'b110, "R6");
        send(1, 200,  26'h2000000, 0, 2'b11, 3'b000, 32'hFF800000, 3'b110, "R6");
        // R9 largest finite, exact
        send(0, 127,  26'h3FFFFFC, 0, 2'b00, 3'b000, 32'h7F7FFFFF, 3'b000, "R9");
        // R7 exact denormals
        send(0, -127, 26'h2000000, 0, 2'b00, 3'b000, 32'h00400000, 3'b000, "R7");
        send(0, -149, 26'h2000000, 0, 2'b00, 3'b000, 32'h00000001, 3'b000, "R7");
        // R8 underflow
        send(0, -150, 26'h2000000, 0, 2'b00, 3'b000, 32'h00000000, 3'b101, "R8");
        send(0, -150, 26'h2000000, 0, 2'b10, 3'b000, 32'h00000001, 3'b101, "R8");
        send(0, -127, 26'h3FFFFFF, 0, 2'b00, 3'b000, 32'h00800000, 3'b101, "R8");
        send(1, -500, 26'h2000000, 0, 2'b11, 3'b000, 32'h80000001, 3'b101, "R8");
        // R10 NaN wins over infinity; R11 specials
        send(1, 0,    26'h2000000, 0, 2'b00, 3'b110, 32'h7FC00000, 3'b000, "R10");
        send(1, 0,    26'h2000000, 1, 2'b00, 3'b010, 32'hFF800000, 3'b000, "R11");
        send(1, 0,    26'h2000000, 1, 2'b10, 3'b001, 32'h80000000, 3'b000, "R11");
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R12", "results outstanding", 32'(sb.size()), 32'd0);
        check(out_valid == 1'b0, "R12", "drained", 32'(out_valid), 32'd0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule